// File: doc/BRIEF.md
# Write-Protection Command Sequencer

This block sits between the host write port of a byte-wide non-volatile memory and its page-load controller. It watches each host write as an address/data pair. It decides whether that write may reach the array, and it issues a registered one-cycle write pulse, together with the address and data, only for writes it admits. On a newly shipped device protection is off and every qualified write is admitted. The first time the host issues the three-write unlock prefix, protection turns on and stays on. From then on, data can only be written inside the single byte-or-page window that each unlock prefix opens.

The window admits at most `PAGE_BYTES` data writes. It closes early if the host leaves `BLC_CYCLES` clock cycles without a write. A longer six-write command turns protection off again, after a `WC_CYCLES` busy period. The protection flag models a non-volatile bit, so the ordinary reset (a power cycle) leaves it unchanged. Only the `nv_clear` input, which stands for the factory-erased state, clears it.

Writes are qualified from the host strobes. A write starts on the cycle in which chip select and write strobe are both low while output enable is high. It is ignored while the power-good input is low.

Top module: `wp_cmd_seq`

## Requirements
- R1: With `nv_clear` and `rst` applied together, `prot_on`, `win_open` and `pass_wr` are 0. While unprotected, every qualified write produces `pass_wr` high for exactly one cycle, on the clock edge after the write is seen, with `pass_addr`/`pass_data` equal to the write's address and data.
- R2: A write counts only on the first cycle in which `ce_n`=0, `we_n`=0 and `oe_n`=1 hold together. Holding that state for many cycles counts once. A write made with `oe_n`=0, or while `pwr_good`=0, is not admitted.
- R3: The three writes 8'hAA at address 13'h1555, then 8'h55 at 13'h0AAA, then 8'hA0 at 13'h1555 set `prot_on` to 1 and open the window (`win_open`=1) on the edge of the third write. This happens whether protection was on or off before.
- R4: While `prot_on`=1 and the window is closed, no write is admitted. This covers plain data writes and the command writes themselves.
- R5: An open window admits at most `PAGE_BYTES` data writes. It closes on the edge of the last one, and a further write is then blocked.
- R6: An open window closes after `BLC_CYCLES` consecutive cycles without a write, counted from the unlock or from the last admitted write. `prot_on` stays 1.
- R7: The six writes AA@1555, 55@0AAA, 80@1555, AA@1555, 55@0AAA, 20@1555 leave `prot_on` at 1 for `WC_CYCLES` cycles and then clear it. Writes during that busy period are not admitted. Afterwards, writes are admitted again.
- R8: A write that does not match the next expected command step returns the sequencer to its start. If that write is itself AA@1555, it is taken as a new first step. An interrupted prefix therefore opens no window.
- R9: `rst` leaves `prot_on` unchanged, but it closes the window and discards a partly entered command sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power cycle); keeps the protection flag |
| nv_clear | input | 1 | Clears the non-volatile protection flag (shipped state) |
| pwr_good | input | 1 | Supply good; low blocks all writes |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Host write address |
| data | input | DATA_W | Host write data |
| pass_wr | output | 1 | One-cycle pulse: admitted write toward the page-load controller |
| pass_addr | output | ADDR_W | Address of the admitted write |
| pass_data | output | DATA_W | Data of the admitted write |
| prot_on | output | 1 | Protection flag |
| win_open | output | 1 | Unlock window currently open |

## Verification
The bound checker watches, on every cycle, the properties of the admitted-write pulse. It is only one cycle wide. It only follows a qualified strobe taken with power good. It carries the address and data of that strobe. It never appears while protection was on and no window was open. The checker also ties the flag to the window: the window implies protection, protection rises only as a window opens, and protection falls with no window or pulse present. The exact command orderings cannot be seen cycle by cycle and are left to the directed scenarios: restart after a mismatch, the byte limit and idle timeout of the window, the length of the busy period after the disable command, and the survival of the flag across reset.

// File: rtl/wp_pkg.sv
package wp_pkg;

  // command sequencer progress
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_GOT_AA,
    SQ_GOT_55,
    SQ_GOT_80,
    SQ_GOT_AA2,
    SQ_GOT_552
  } sq_state_t;

  localparam logic [7:0] CMD_LEAD   = 8'hAA;
  localparam logic [7:0] CMD_SECOND = 8'h55;
  localparam logic [7:0] CMD_UNLOCK = 8'hA0;
  localparam logic [7:0] CMD_EXTEND = 8'h80;
  localparam logic [7:0] CMD_OFF    = 8'h20;

endpackage

// File: rtl/wp_write_detect.sv
module wp_write_detect (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr_evt
);

  logic wr_act;
  logic wr_act_q;

  assign wr_act = ~ce_n & ~we_n & oe_n;

  always_ff @(posedge clk) begin
    if (rst) wr_act_q <= 1'b0;
    else     wr_act_q <= wr_act;
  end

  // a write starts on the first cycle the strobe combination appears
  assign wr_evt = wr_act & ~wr_act_q & pwr_good;

endmodule

// File: rtl/wp_cmd_match.sv
module wp_cmd_match
  import wp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_HI = 13'h1555,
  parameter logic [ADDR_W-1:0] ADDR_LO = 13'h0AAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              unlock_hit,
  output logic              disable_hit
);

  sq_state_t state_q, state_d;
  logic is_lead, is_second, is_unlock, is_extend, is_off;
  sq_state_t restart;

  assign is_lead   = (addr == ADDR_HI) && (data == DATA_W'(CMD_LEAD));
  assign is_second = (addr == ADDR_LO) && (data == DATA_W'(CMD_SECOND));
  assign is_unlock = (addr == ADDR_HI) && (data == DATA_W'(CMD_UNLOCK));
  assign is_extend = (addr == ADDR_HI) && (data == DATA_W'(CMD_EXTEND));
  assign is_off    = (addr == ADDR_HI) && (data == DATA_W'(CMD_OFF));

  // a mismatching write may itself begin a new sequence
  assign restart = is_lead ? SQ_GOT_AA : SQ_IDLE;

  always_comb begin
    state_d     = state_q;
    unlock_hit  = 1'b0;
    disable_hit = 1'b0;
    if (evt) begin
      case (state_q)
        SQ_IDLE:    state_d = restart;
        SQ_GOT_AA:  state_d = is_second ? SQ_GOT_55 : restart;
        SQ_GOT_55: begin
          if (is_unlock) begin
            unlock_hit = 1'b1;
            state_d    = SQ_IDLE;
          end else if (is_extend) begin
            state_d = SQ_GOT_80;
          end else begin
            state_d = restart;
          end
        end
        SQ_GOT_80:  state_d = is_lead ? SQ_GOT_AA2 : SQ_IDLE;
        SQ_GOT_AA2: state_d = is_second ? SQ_GOT_552 : restart;
        SQ_GOT_552: begin
          if (is_off) begin
            disable_hit = 1'b1;
            state_d     = SQ_IDLE;
          end else begin
            state_d = restart;
          end
        end
        default:    state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SQ_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/wp_window.sv
module wp_window #(
  parameter int PAGE_BYTES = 64,
  parameter int BLC_CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic open_req,
  input  logic data_wr,
  output logic win_open
);

  localparam int BW = $clog2(PAGE_BYTES + 1);
  localparam int IW = $clog2(BLC_CYCLES + 1);
  localparam logic [BW-1:0] LAST_BYTE = BW'(PAGE_BYTES - 1);
  localparam logic [IW-1:0] LAST_IDLE = IW'(BLC_CYCLES - 1);

  logic          win_q;
  logic [BW-1:0] bytes_q;
  logic [IW-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q   <= 1'b0;
      bytes_q <= '0;
      idle_q  <= '0;
    end else if (open_req) begin
      win_q   <= 1'b1;
      bytes_q <= '0;
      idle_q  <= '0;
    end else if (win_q) begin
      if (data_wr) begin
        idle_q <= '0;
        if (bytes_q == LAST_BYTE) win_q <= 1'b0;
        else                      bytes_q <= bytes_q + 1'b1;
      end else if (idle_q == LAST_IDLE) begin
        win_q <= 1'b0;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  assign win_open = win_q;

endmodule

// File: rtl/wp_prot_flag.sv
module wp_prot_flag #(
  parameter int WC_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic nv_clear,
  input  logic set_prot,
  input  logic dis_start,
  output logic prot_on,
  output logic dis_busy
);

  localparam int CW = $clog2(WC_CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(WC_CYCLES - 1);

  logic          prot_q;
  logic          pend_q;
  logic [CW-1:0] cnt_q;
  logic          expire;

  assign expire = pend_q && (cnt_q == LAST_CNT);

  // busy period after the disable command; lost on a power cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (dis_start) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else if (pend_q) begin
      if (expire) pend_q <= 1'b0;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end

  // non-volatile bit: ordinary reset leaves it alone
  always_ff @(posedge clk) begin
    if (nv_clear)      prot_q <= 1'b0;
    else if (set_prot) prot_q <= 1'b1;
    else if (expire)   prot_q <= 1'b0;
  end

  assign prot_on  = prot_q;
  assign dis_busy = pend_q;

endmodule

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64,
  parameter int BLC_CYCLES = 200,
  parameter int WC_CYCLES  = 1000,
  parameter logic [ADDR_W-1:0] ADDR_HI = 13'h1555,
  parameter logic [ADDR_W-1:0] ADDR_LO = 13'h0AAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nv_clear,
  input  logic              pwr_good,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              pass_wr,
  output logic [ADDR_W-1:0] pass_addr,
  output logic [DATA_W-1:0] pass_data,
  output logic              prot_on,
  output logic              win_open
);

  logic wr_evt;
  logic seq_evt;
  logic unlock_hit;
  logic disable_hit;
  logic dis_busy;
  logic win_wr;
  logic admit;
  logic prot_w;
  logic win_w;

  wp_write_detect u_detect (
    .clk      (clk),
    .rst      (rst),
    .pwr_good (pwr_good),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .wr_evt   (wr_evt)
  );

  // writes inside an open window are data, never commands
  assign seq_evt = wr_evt & ~win_w & ~dis_busy;
  assign win_wr  = wr_evt & win_w;

  wp_cmd_match #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ADDR_HI (ADDR_HI),
    .ADDR_LO (ADDR_LO)
  ) u_match (
    .clk         (clk),
    .rst         (rst),
    .evt         (seq_evt),
    .addr        (addr),
    .data        (data),
    .unlock_hit  (unlock_hit),
    .disable_hit (disable_hit)
  );

  wp_window #(
    .PAGE_BYTES (PAGE_BYTES),
    .BLC_CYCLES (BLC_CYCLES)
  ) u_window (
    .clk      (clk),
    .rst      (rst | nv_clear),
    .open_req (unlock_hit),
    .data_wr  (win_wr),
    .win_open (win_w)
  );

  wp_prot_flag #(
    .WC_CYCLES (WC_CYCLES)
  ) u_flag (
    .clk       (clk),
    .rst       (rst),
    .nv_clear  (nv_clear),
    .set_prot  (unlock_hit),
    .dis_start (disable_hit),
    .prot_on   (prot_w),
    .dis_busy  (dis_busy)
  );

  assign admit = wr_evt & ~dis_busy & (win_w | ~prot_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_wr   <= 1'b0;
      pass_addr <= '0;
      pass_data <= '0;
    end else begin
      pass_wr <= admit;
      if (admit) begin
        pass_addr <= addr;
        pass_data <= data;
      end
    end
  end

  assign prot_on  = prot_w;
  assign win_open = win_w;

endmodule

// File: rtl/wp_cmd_seq_sva.sv
module wp_cmd_seq_sva #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_good,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] data,
  input logic              pass_wr,
  input logic [ADDR_W-1:0] pass_addr,
  input logic [DATA_W-1:0] pass_data,
  input logic              prot_on,
  input logic              win_open
);

  assert_pass_source_R2: assert property (@(posedge clk) disable iff (rst)
    pass_wr |-> $past(!ce_n && !we_n && oe_n && pwr_good));

  assert_pass_single_R2: assert property (@(posedge clk) disable iff (rst)
    pass_wr |=> !pass_wr);

  assert_pass_payload_R1: assert property (@(posedge clk) disable iff (rst)
    pass_wr |-> (pass_addr == $past(addr)) && (pass_data == $past(data)));

  assert_no_pass_locked_R4: assert property (@(posedge clk) disable iff (rst)
    pass_wr |-> (!$past(prot_on) || $past(win_open)));

  assert_window_needs_prot_R3: assert property (@(posedge clk) disable iff (rst)
    win_open |-> prot_on);

  assert_prot_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(prot_on) |-> win_open);

  assert_prot_fall_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(prot_on) |-> (!win_open && !pass_wr));

endmodule

bind wp_cmd_seq wp_cmd_seq_sva #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_sva (
  .clk       (clk),
  .rst       (rst),
  .pwr_good  (pwr_good),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .addr      (addr),
  .data      (data),
  .pass_wr   (pass_wr),
  .pass_addr (pass_addr),
  .pass_data (pass_data),
  .prot_on   (prot_on),
  .win_open  (win_open)
);

// File: tb/wp_cmd_seq_tb.sv
`timescale 1ns/1ps
module wp_cmd_seq_tb;

  localparam int AW  = 13;
  localparam int DW  = 8;
  localparam int PB  = 4;
  localparam int BLC = 16;
  localparam int WC  = 10;

  logic          clk = 1'b0;
  logic          rst, nv_clear, pwr_good, ce_n, oe_n, we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic          pass_wr, prot_on, win_open;
  logic [AW-1:0] pass_addr;
  logic [DW-1:0] pass_data;

  int n_checks = 0;
  int n_errors = 0;
  int n_pass   = 0;
  logic [AW-1:0] last_addr = '0;
  logic [DW-1:0] last_data = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wp_cmd_seq #(
    .ADDR_W (AW), .DATA_W (DW), .PAGE_BYTES (PB),
    .BLC_CYCLES (BLC), .WC_CYCLES (WC)
  ) u_dut (
    .clk (clk), .rst (rst), .nv_clear (nv_clear), .pwr_good (pwr_good),
    .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n), .addr (addr), .data (data),
    .pass_wr (pass_wr), .pass_addr (pass_addr), .pass_data (pass_data),
    .prot_on (prot_on), .win_open (win_open)
  );

  // observe admitted writes away from the active edge
  always @(negedge clk) begin
    if (!rst && pass_wr) begin
      n_pass++;
      last_addr = pass_addr;
      last_data = pass_data;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; data = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(13'h1555, 8'hAA);
    wr(13'h0AAA, 8'h55);
    wr(13'h1555, 8'hA0);
  endtask

  task automatic t_reset_state();
    rst = 1'b1; nv_clear = 1'b1;
    idle(4);
    check("R1", "prot_on after shipped reset", prot_on, 0);
    check("R1", "win_open after shipped reset", win_open, 0);
    check("R1", "pass_wr after shipped reset", pass_wr, 0);
    rst = 1'b0; nv_clear = 1'b0;
    idle(2);
  endtask

  task automatic t_open_write();
    int p0 = n_pass;
    wr(13'h0123, 8'h5A);
    check("R1", "unprotected write admitted", n_pass - p0, 1);
    check("R1", "admitted address", int'(last_addr), 'h0123);
    check("R1", "admitted data", int'(last_data), 'h5A);
  endtask

  task automatic t_qualify();
    int p0 = n_pass;
    @(negedge clk);
    addr = 13'h0040; data = 8'h11; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    idle(2);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    idle(2);
    check("R2", "write with output enable low", n_pass - p0, 0);
    pwr_good = 1'b0;
    wr(13'h0041, 8'h22);
    pwr_good = 1'b1;
    idle(1);
    check("R2", "write with power not good", n_pass - p0, 0);
    @(negedge clk);
    addr = 13'h0042; data = 8'h33; ce_n = 1'b0; we_n = 1'b0;
    idle(5);
    ce_n = 1'b1; we_n = 1'b1;
    idle(2);
    check("R2", "held strobe counted once", n_pass - p0, 1);
    check("R2", "held strobe data", int'(last_data), 'h33);
  endtask

  task automatic t_unlock_timeout();
    int p0 = n_pass;
    unlock();
    check("R3", "prot_on after first unlock", prot_on, 1);
    check("R3", "win_open after unlock", win_open, 1);
    check("R3", "unlock writes admitted while unprotected", n_pass - p0, 3);
    wr(13'h0200, 8'h01);
    wr(13'h0201, 8'h02);
    check("R3", "window data admitted", n_pass - p0, 5);
    idle(BLC + 4);
    check("R6", "window closed after idle time", win_open, 0);
    check("R6", "prot_on kept after timeout", prot_on, 1);
  endtask

  task automatic t_locked();
    int p0 = n_pass;
    wr(13'h0300, 8'h77);
    check("R4", "plain write blocked when protected", n_pass - p0, 0);
    wr(13'h1555, 8'hAA);
    wr(13'h0AAA, 8'h55);
    check("R4", "command writes not admitted", n_pass - p0, 0);
    wr(13'h1555, 8'hA0);
    check("R4", "unlock command not admitted", n_pass - p0, 0);
    check("R3", "window opens when already protected", win_open, 1);
  endtask

  task automatic t_page_limit();
    int p0 = n_pass;
    for (int i = 0; i < PB; i++) wr(13'h0400 + AW'(i), 8'hC0 + DW'(i));
    check("R5", "page bytes admitted", n_pass - p0, PB);
    check("R5", "window closed at page limit", win_open, 0);
    check("R5", "last page byte data", int'(last_data), 'hC0 + PB - 1);
    wr(13'h0410, 8'hEE);
    check("R5", "write after page limit blocked", n_pass - p0, PB);
  endtask

  task automatic t_mismatch();
    int p0 = n_pass;
    wr(13'h1555, 8'hAA);
    wr(13'h0100, 8'h12);
    wr(13'h0AAA, 8'h55);
    wr(13'h1555, 8'hA0);
    check("R8", "interrupted prefix opens no window", win_open, 0);
    check("R8", "mismatched writes discarded", n_pass - p0, 0);
    wr(13'h1555, 8'hAA);
    wr(13'h1555, 8'hAA);
    wr(13'h0AAA, 8'h55);
    wr(13'h1555, 8'hA0);
    check("R8", "repeated lead restarts sequence", win_open, 1);
    idle(BLC + 4);
  endtask

  task automatic t_persist();
    int p0 = n_pass;
    wr(13'h1555, 8'hAA);
    wr(13'h0AAA, 8'h55);
    rst = 1'b1; idle(2); rst = 1'b0; idle(1);
    check("R9", "prot_on survives reset", prot_on, 1);
    wr(13'h1555, 8'hA0);
    check("R9", "partial prefix lost at reset", win_open, 0);
    unlock();
    check("R9", "window open before reset", win_open, 1);
    rst = 1'b1; idle(2); rst = 1'b0; idle(1);
    check("R9", "window closed by reset", win_open, 0);
    check("R9", "prot_on still set", prot_on, 1);
    check("R9", "nothing admitted", n_pass - p0, 0);
  endtask

  task automatic t_disable();
    int p0 = n_pass;
    wr(13'h1555, 8'hAA);
    wr(13'h0AAA, 8'h55);
    wr(13'h1555, 8'h80);
    wr(13'h1555, 8'hAA);
    wr(13'h0AAA, 8'h55);
    wr(13'h1555, 8'h20);
    check("R7", "prot_on held during busy period", prot_on, 1);
    wr(13'h0500, 8'h99);
    check("R7", "write during busy period blocked", n_pass - p0, 0);
    idle(WC + 4);
    check("R7", "prot_on cleared after busy period", prot_on, 0);
    wr(13'h0501, 8'h3C);
    check("R7", "write admitted after disable", n_pass - p0, 1);
    check("R7", "admitted data after disable", int'(last_data), 'h3C);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1; nv_clear = 1'b1; pwr_good = 1'b1;
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; data = '0;
    t_reset_state();
    t_open_write();
    t_qualify();
    t_unlock_timeout();
    t_locked();
    t_page_limit();
    t_mismatch();
    t_persist();
    t_disable();
    idle(2);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule